// File: doc/BRIEF.md
# Timer Compare and PWM Channel

This block is an up-counting timer with a single compare channel that drives one output pin. The counter climbs from zero to the active reload value, wraps back to zero and, on that wrap, raises an update event. The channel compares the running count against the active compare value. From that comparison it builds an internal reference waveform in one of three ways: a toggle on every match, or one of two pulse-width modulation shapes.

The reload and compare values are double-buffered. Each one has its own preload enable. With preload off, a write reaches the active value at once. With preload on, the write is parked in a holding register and copied to the active value only on the next update event. A software strobe forces an update event, so that both active values can be primed before the counter starts. A polarity select and an output enable shape the pin. A sticky match flag with a write-one-to-clear input and a maskable interrupt report compare matches.

Top module: `tmr_pwm_chan`

## Requirements
- R1: After reset the count is 0. While `cnt_en` is 1 the count steps by one per clock from 0 up to the active reload value inclusive, then goes to 0 on the next clock. `upd_evt` is high in the cycle whose closing edge performs that wrap. While `cnt_en` is 0 the count holds. After reset the active reload value is all ones and the active compare value is 0.
- R2: With `mode` = 3'b011 the reference inverts at every clock edge in which the counter is enabled and the count equals the active compare value. The reference is 0 after reset.
- R3: With `mode` = 3'b110 the reference is 1 while count < active compare value and 0 otherwise. A compare value of 0 therefore gives 0% duty, and a compare value above the reload value gives 100% duty.
- R4: With `mode` = 3'b111 the reference is 0 while count < active compare value and 1 otherwise.
- R5: Every other `mode` code holds the reference at 0.
- R6: With `cmp_pre_en` = 0, a `cmp_wr` pulse sets the active compare value at the next edge. With `cmp_pre_en` = 1 the written value becomes active only at an edge that carries an update event.
- R7: With `arr_pre_en` = 0, an `arr_wr` pulse sets the active reload value at the next edge. With `arr_pre_en` = 1 the written value becomes active only at an edge that carries an update event. A write in the same cycle as the update is the value that gets loaded.
- R8: A `upd_gen` pulse makes `upd_evt` high in that cycle. At the next edge it clears the count to 0 and loads both held values into their active registers, whether or not the counter is enabled.
- R9: `pwm_out` is the reference XOR `pol` while `out_en` is 1, and is 0 while `out_en` is 0.
- R10: `match_flag` is set at any edge where the counter is enabled and the count equals the active compare value, in any mode. It stays set until a `flag_clr` pulse; if a new match and a clear arrive together, the set wins.
- R11: `irq` is high exactly while `match_flag` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter run enable |
| mode | input | 3 | Reference mode: 011 toggle, 110 PWM 1, 111 PWM 2 |
| cmp_pre_en | input | 1 | Compare preload enable |
| arr_pre_en | input | 1 | Reload preload enable |
| pol | input | 1 | Output polarity, 1 inverts |
| out_en | input | 1 | Output enable |
| irq_en | input | 1 | Match interrupt enable |
| upd_gen | input | 1 | Software update strobe |
| arr_wr | input | 1 | Reload write strobe |
| arr_wdata | input | CNT_W | Reload write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| cnt_o | output | CNT_W | Current count |
| upd_evt | output | 1 | Update event in this cycle |
| pwm_out | output | 1 | Channel output pin |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |

## Verification
On every cycle the assertions check the following:
- the wrap to zero at the reload value;
- the count holding while the counter is stopped;
- the clear caused by the update strobe;
- the active reload and compare values staying frozen between update events while preload is on;
- the toggle inverting on each match;
- the flag being set by a match and staying sticky.

Other properties can only be shown by the bench's sweeps, each of which it compares against an arithmetic model:
- the duty-cycle shapes of both PWM modes across every compare value from 0 to above the reload;
- the exact cycle in which a parked value takes effect;
- polarity and enable gating;
- set-over-clear priority on the flag.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;
    localparam logic [2:0] MODE_TOGGLE = 3'b011;
    localparam logic [2:0] MODE_PWM_LO = 3'b110;
    localparam logic [2:0] MODE_PWM_HI = 3'b111;
endpackage

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             upd_gen,
    input  logic             arr_pre_en,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr_hold;
        logic [CNT_W-1:0] arr_act;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d  = st_q;
        wrap  = cnt_en && (st_q.cnt == st_q.arr_act);
        upd_o = upd_gen || wrap;

        if (upd_gen || wrap) begin
            st_d.cnt = '0;
        end else if (cnt_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (arr_wr) begin
            st_d.arr_hold = arr_wdata;
        end

        if (arr_wr && !arr_pre_en) begin
            st_d.arr_act = arr_wdata;
        end else if (upd_o) begin
            st_d.arr_act = arr_wr ? arr_wdata : st_q.arr_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.arr_hold <= '1;
            st_q.arr_act  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && st_q.cnt == st_q.arr_act) |=> (st_q.cnt == '0));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !upd_gen) |=> $stable(st_q.cnt));
    assert_force_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_gen |=> (st_q.cnt == '0));
    assert_arr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pre_en && !upd_gen && !(cnt_en && st_q.cnt == st_q.arr_act)) |=> $stable(st_q.arr_act));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             upd_i,
    input  logic [2:0]       mode,
    input  logic             cmp_pre_en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic             ref_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp_hold;
        logic [CNT_W-1:0] cmp_act;
        logic             tog;
        logic             flag;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;
    logic       below;

    always_comb begin
        st_d  = st_q;
        hit   = cnt_en && (cnt_i == st_q.cmp_act);
        below = (cnt_i < st_q.cmp_act);

        if (cmp_wr) begin
            st_d.cmp_hold = cmp_wdata;
        end
        if (cmp_wr && !cmp_pre_en) begin
            st_d.cmp_act = cmp_wdata;
        end else if (upd_i) begin
            st_d.cmp_act = cmp_wr ? cmp_wdata : st_q.cmp_hold;
        end

        if (hit && mode == MODE_TOGGLE) begin
            st_d.tog = ~st_q.tog;
        end

        if (hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end

        case (mode)
            MODE_TOGGLE: ref_o = st_q.tog;
            MODE_PWM_LO: ref_o = below;
            MODE_PWM_HI: ref_o = ~below;
            default:     ref_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp_hold <= '0;
            st_q.cmp_act  <= '0;
            st_q.tog      <= 1'b0;
            st_q.flag     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_TOGGLE) |=> (st_q.tog != $past(st_q.tog)));
    assert_cmp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pre_en && !upd_i) |=> $stable(st_q.cmp_act));
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.flag);
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag);
endmodule

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [2:0]       mode,
    input  logic             cmp_pre_en,
    input  logic             arr_pre_en,
    input  logic             pol,
    input  logic             out_en,
    input  logic             irq_en,
    input  logic             upd_gen,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_evt,
    output logic             pwm_out,
    output logic             match_flag,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_w;
    logic             upd_w;
    logic             ref_w;
    logic             flag_w;

    tmr_cnt_unit #(.CNT_W(CNT_W)) cnt_u (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .upd_gen    (upd_gen),
        .arr_pre_en (arr_pre_en),
        .arr_wr     (arr_wr),
        .arr_wdata  (arr_wdata),
        .cnt_o      (cnt_w),
        .upd_o      (upd_w)
    );

    tmr_cmp_unit #(.CNT_W(CNT_W)) cmp_u (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .cnt_i      (cnt_w),
        .upd_i      (upd_w),
        .mode       (mode),
        .cmp_pre_en (cmp_pre_en),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .flag_clr   (flag_clr),
        .ref_o      (ref_w),
        .flag_o     (flag_w)
    );

    always_comb begin
        pwm_out    = out_en & (ref_w ^ pol);
        irq        = flag_w & irq_en;
        cnt_o      = cnt_w;
        upd_evt    = upd_w;
        match_flag = flag_w;
    end

    assert_upd_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_gen |-> upd_evt);
endmodule

// File: tb/tmr_pwm_chan_tb_top.sv
module tmr_pwm_chan_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_cnt_en = 0, i_cmp_pre_en = 0, i_arr_pre_en = 0, i_pol = 0, i_out_en = 1;
    logic i_irq_en = 0, i_upd_gen = 0, i_arr_wr = 0, i_cmp_wr = 0, i_flag_clr = 0;
    logic [2:0]   i_mode = 3'b110;
    logic [W-1:0] i_arr_wdata = '0, i_cmp_wdata = '0;
    logic [W-1:0] cnt_o;
    logic upd_evt, pwm_out, match_flag, irq;

    int n_run = 0, n_fail = 0, n_cyc = 0;
    string cur_tag = "R3";

    // reference model state
    int m_cnt = 0, m_arr_hold = 255, m_arr_act = 255, m_cmp_hold = 0, m_cmp_act = 0;
    bit m_tog = 0, m_flag = 0;

    always #4 clk = ~clk;

    tmr_pwm_chan #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(i_cnt_en), .mode(i_mode),
        .cmp_pre_en(i_cmp_pre_en), .arr_pre_en(i_arr_pre_en), .pol(i_pol),
        .out_en(i_out_en), .irq_en(i_irq_en), .upd_gen(i_upd_gen),
        .arr_wr(i_arr_wr), .arr_wdata(i_arr_wdata), .cmp_wr(i_cmp_wr),
        .cmp_wdata(i_cmp_wdata), .flag_clr(i_flag_clr), .cnt_o(cnt_o),
        .upd_evt(upd_evt), .pwm_out(pwm_out), .match_flag(match_flag), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, n_cyc);
        end
    endtask

    task automatic cyc();
        bit e_upd, e_hit, e_ref, e_out;
        #1;
        e_upd = i_upd_gen || (i_cnt_en && m_cnt == m_arr_act);
        e_hit = i_cnt_en && m_cnt == m_cmp_act;
        case (i_mode)
            3'b011:  e_ref = m_tog;
            3'b110:  e_ref = (m_cnt < m_cmp_act);
            3'b111:  e_ref = !(m_cnt < m_cmp_act);
            default: e_ref = 1'b0;
        endcase
        e_out = i_out_en ? (e_ref ^ i_pol) : 1'b0;
        chk("R1", int'(cnt_o), m_cnt);
        chk(i_upd_gen ? "R8" : "R1", int'(upd_evt), int'(e_upd));
        chk(cur_tag, int'(pwm_out), int'(e_out));
        chk("R10", int'(match_flag), int'(m_flag));
        chk("R11", int'(irq), int'(m_flag && i_irq_en));
        @(posedge clk);
        n_cyc++;
        if (e_upd) m_cnt = 0;
        else if (i_cnt_en) m_cnt = m_cnt + 1;
        if (i_arr_wr && !i_arr_pre_en) m_arr_act = int'(i_arr_wdata);
        else if (e_upd) m_arr_act = i_arr_wr ? int'(i_arr_wdata) : m_arr_hold;
        if (i_arr_wr) m_arr_hold = int'(i_arr_wdata);
        if (i_cmp_wr && !i_cmp_pre_en) m_cmp_act = int'(i_cmp_wdata);
        else if (e_upd) m_cmp_act = i_cmp_wr ? int'(i_cmp_wdata) : m_cmp_hold;
        if (i_cmp_wr) m_cmp_hold = int'(i_cmp_wdata);
        if (e_hit && i_mode == 3'b011) m_tog = !m_tog;
        if (e_hit) m_flag = 1;
        else if (i_flag_clr) m_flag = 0;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr_arr(input int v);
        i_arr_wr = 1; i_arr_wdata = W'(v); cyc(); i_arr_wr = 0;
    endtask

    task automatic wr_cmp(input int v);
        i_cmp_wr = 1; i_cmp_wdata = W'(v); cyc(); i_cmp_wr = 0;
    endtask

    task automatic force_upd();
        i_upd_gen = 1; cyc(); i_upd_gen = 0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // reset state (R1)
        chk("R1", int'(cnt_o), 0);
        chk("R1", int'(upd_evt), 0);
        chk("R9", int'(pwm_out), 0);
        chk("R10", int'(match_flag), 0);
        chk("R11", int'(irq), 0);
        @(negedge clk);

        // R3/R4 duty sweep, all compare values including 0% and 100%
        for (int md = 0; md < 2; md++) begin
            i_mode = md == 0 ? 3'b110 : 3'b111;
            cur_tag = md == 0 ? "R3" : "R4";
            for (int a = 3; a <= 6; a += 3) begin
                wr_arr(a);
                for (int c = 0; c <= a + 1; c++) begin
                    wr_cmp(c);
                    force_upd();
                    i_cnt_en = 1;
                    run(2 * (a + 1));
                    i_cnt_en = 0;
                end
            end
        end
        cur_tag = "R1";
        run(3);   // counter holds while stopped

        // R2 toggle on match
        cur_tag = "R2"; i_mode = 3'b011;
        wr_arr(4); wr_cmp(2); force_upd();
        i_cnt_en = 1; run(20); i_cnt_en = 0;

        // R5 other mode codes
        cur_tag = "R5";
        for (int md = 0; md < 8; md++) begin
            if (md == 3 || md >= 6) continue;
            i_mode = 3'(md); i_cnt_en = 1; run(6); i_cnt_en = 0;
        end

        // R6 compare preload
        cur_tag = "R6"; i_mode = 3'b110;
        wr_arr(7); wr_cmp(2); force_upd();
        i_cmp_pre_en = 1; i_cnt_en = 1;
        run(3); wr_cmp(6); run(16);
        i_cmp_pre_en = 0; run(2); wr_cmp(1); run(9);

        // R7 reload preload
        cur_tag = "R7"; i_arr_pre_en = 1;
        run(2); wr_arr(2); run(14);
        i_arr_pre_en = 0; wr_arr(5); run(14);
        i_arr_pre_en = 1;
        while (m_cnt != m_arr_act) cyc();
        wr_arr(3); run(10);   // write coincides with the wrap
        i_arr_pre_en = 0;

        // R8 forced update mid-count with both preloads on
        cur_tag = "R8"; i_arr_pre_en = 1; i_cmp_pre_en = 1;
        wr_arr(6); wr_cmp(4); run(1); force_upd(); run(10);
        i_cnt_en = 0; wr_cmp(2); force_upd(); run(2); i_cnt_en = 1; run(8);
        i_arr_pre_en = 0; i_cmp_pre_en = 0;

        // R9 polarity and enable
        cur_tag = "R9";
        for (int p = 0; p < 2; p++) begin
            for (int oe = 0; oe < 2; oe++) begin
                i_pol = 1'(p); i_out_en = 1'(oe); run(8);
            end
        end
        i_pol = 0; i_out_en = 1;

        // R10/R11 flag clear, interrupt enable, set beats clear
        cur_tag = "R10";
        wr_arr(5); wr_cmp(3); force_upd();
        run(2);
        i_flag_clr = 1; cyc(); i_flag_clr = 0; run(2);
        i_irq_en = 1; run(5);
        while (m_cnt != m_cmp_act) cyc();
        i_flag_clr = 1; cyc(); i_flag_clr = 0;   // clear during a match
        run(2);
        i_flag_clr = 1; cyc(); i_flag_clr = 0;
        i_irq_en = 0; run(4); i_irq_en = 1; run(4);
        i_cnt_en = 0; run(2);

        finish_run();
    end
endmodule